// File: doc/BRIEF.md
# Spike-to-Synapse Address Event Sequencer

This controller turns the spike states of a domain of binary sources (sensor elements and neuron outputs) into addressed synapse activations, without any direct wire from a source to a synapse. Each round it first replays activations that were deferred by earlier rounds. It then polls every source in ascending index order through a single one-bit read port. A multiplexer outside the block picks the source named by `rd_addr`, and the act of reading clears that source's spike. For every source found spiking, the block walks that source's slice of an internal connection table. Each table entry names a target synapse and a delay counted in whole rounds. Entries with delay 0 produce an active-low set strobe on the synapse address bus at once. Entries with a non-zero delay are parked in a pending table until their round comes due.

When every source has been polled, the block lowers the global stimulate line for a programmable number of cycles. It then lowers the global clear line for a programmable number of cycles, raises a one-cycle round-complete flag and starts the next round. This repeats for as long as reset is released. The connection table and the per-source base/count table are written through plain configuration ports, normally while reset is held.

The read port and the activation strobes run on fixed timing and have no handshake and no back-pressure. A receiver must accept a set strobe in the cycle it is shown.

Top module: `spike_route_seq`

## Requirements
- R1: While reset is low and in the first cycle after it, `set_n`, `stim_n` and `clr_n` are high, and `round_done` and `rd_en` are low.
- R2: Each round reads every source exactly once, in ascending index order. Each read is one cycle with `rd_en` high and the index on `rd_addr`. `rd_bit` is sampled in that same cycle.
- R3: A source read as spiking with a count c > 0 visits the table entries base, base+1, …, base+c-1 in that order, wrapping modulo the table depth. Every visited entry whose 2-bit delay field is 0 gives one low cycle of `set_n` with `syn_addr` equal to that entry's synapse field. Sources are handled in ascending index order.
- R4: A source that is not spiking, or whose count is 0, causes no `set_n` strobe.
- R5: A visited entry with delay d (1 to 3) is issued d rounds later, not in the current round. Delayed activations are issued at the start of that round, in ascending entry index order, before any read of that round.
- R6: If the same entry is visited more than once while pending for the same round (shared table slices), it is issued only once in that round.
- R7: After the last read and its activations, `stim_n` is low for max(`stim_len`,1) cycles. `clr_n` goes low in the cycle `stim_n` returns high and stays low for max(`clr_len`,1) cycles. The two lines are never low together, and no `set_n` strobe falls inside either pulse.
- R8: `round_done` is high for exactly one cycle: the first cycle with `clr_n` back high.
- R9: Rounds follow one another without end. The next round's activity begins right after `round_done`, and the pending state carries across rounds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_ent_we | input | 1 | Write strobe for the connection table |
| cfg_ent_idx | input | 5 | Connection table index to write |
| cfg_ent_syn | input | 6 | Target synapse address for the entry |
| cfg_ent_dly | input | 2 | Delay in rounds for the entry (0 = same round) |
| cfg_src_we | input | 1 | Write strobe for the source table |
| cfg_src_idx | input | 3 | Source index to write |
| cfg_src_base | input | 5 | First connection entry of the source |
| cfg_src_cnt | input | 6 | Number of connection entries of the source |
| stim_len | input | 4 | Stimulate pulse length in cycles (0 acts as 1) |
| clr_len | input | 4 | Clear pulse length in cycles (0 acts as 1) |
| rd_en | output | 1 | Read strobe; the selected source's spike is cleared by the read |
| rd_addr | output | 3 | Source index selected for reading |
| rd_bit | input | 1 | Spike state of the selected source |
| set_n | output | 1 | Active-low synapse activate strobe |
| syn_addr | output | 6 | Synapse address qualified by `set_n` |
| stim_n | output | 1 | Active-low global stimulate pulse |
| clr_n | output | 1 | Active-low global clear pulse |
| round_done | output | 1 | One-cycle end-of-round flag |

## Verification
`rd_bit` is consumed in the same cycle `rd_en` is shown, so the bench's spike store clears a source on the clock edge that ends its read. Each activation strobe appears one cycle after the step that issues it. The bench does not pin individual strobe cycles: it gathers all strobes between two `round_done` flags and compares their ordered list with the list its model predicts for that round, which also places each delayed activation in its due round. Pulse widths, the clear following stimulate in the very cycle stimulate rises, and `round_done` in the first cycle after clear are measured cycle by cycle. All outputs are sampled on the falling edge, between active edges.

// File: rtl/srs_pkg.sv
package srs_pkg;
  typedef enum logic [2:0] {
    SQ_REL   = 3'd0,
    SQ_SHIFT = 3'd1,
    SQ_READ  = 3'd2,
    SQ_WALK  = 3'd3,
    SQ_STIM  = 3'd4,
    SQ_CLR   = 3'd5,
    SQ_DONE  = 3'd6
  } seq_state_t;
endpackage

// File: rtl/srs_conn_store.sv
module srs_conn_store #(
  parameter int N_SRC = 8,
  parameter int N_ENT = 32,
  parameter int SYN_W = 6,
  parameter int DLY_W = 2,
  localparam int ENT_W = $clog2(N_ENT),
  localparam int SRC_W = $clog2(N_SRC),
  localparam int CNT_W = $clog2(N_ENT + 1)
) (
  input  logic             clk,
  input  logic             ent_we,
  input  logic [ENT_W-1:0] ent_widx,
  input  logic [SYN_W-1:0] ent_wsyn,
  input  logic [DLY_W-1:0] ent_wdly,
  input  logic             src_we,
  input  logic [SRC_W-1:0] src_widx,
  input  logic [ENT_W-1:0] src_wbase,
  input  logic [CNT_W-1:0] src_wcnt,
  input  logic [ENT_W-1:0] ent_ridx,
  output logic [SYN_W-1:0] ent_rsyn,
  output logic [DLY_W-1:0] ent_rdly,
  input  logic [SRC_W-1:0] src_ridx,
  output logic [ENT_W-1:0] src_rbase,
  output logic [CNT_W-1:0] src_rcnt
);
  logic [SYN_W-1:0] syn_mem  [N_ENT];
  logic [DLY_W-1:0] dly_mem  [N_ENT];
  logic [ENT_W-1:0] base_mem [N_SRC];
  logic [CNT_W-1:0] cnt_mem  [N_SRC];

  always_ff @(posedge clk) begin
    if (ent_we) begin
      syn_mem[ent_widx] <= ent_wsyn;
      dly_mem[ent_widx] <= ent_wdly;
    end
  end

  always_ff @(posedge clk) begin
    if (src_we) begin
      base_mem[src_widx] <= src_wbase;
      cnt_mem[src_widx]  <= src_wcnt;
    end
  end

  assign ent_rsyn  = syn_mem[ent_ridx];
  assign ent_rdly  = dly_mem[ent_ridx];
  assign src_rbase = base_mem[src_ridx];
  assign src_rcnt  = cnt_mem[src_ridx];
endmodule

// File: rtl/srs_pend_table.sv
module srs_pend_table #(
  parameter int N_ENT   = 32,
  parameter int MAX_DLY = 3,
  localparam int ENT_W = $clog2(N_ENT),
  localparam int DLY_W = $clog2(MAX_DLY + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic [ENT_W-1:0] set_idx,
  input  logic [DLY_W-1:0] set_dly,
  input  logic             shift_en,
  input  logic [ENT_W-1:0] q_idx,
  output logic             due
);
  // pend[e][k] : entry e is to be issued k+1 releases from now
  logic [MAX_DLY-1:0] pend [N_ENT];
  logic [MAX_DLY-1:0] set_mask;

  generate
    for (genvar k = 0; k < MAX_DLY; k++) begin : g_mask
      assign set_mask[k] = (set_dly == DLY_W'(k + 1));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int e = 0; e < N_ENT; e++) pend[e] <= '0;
    end else if (shift_en) begin
      for (int e = 0; e < N_ENT; e++) pend[e] <= pend[e] >> 1;
    end else if (set_en) begin
      pend[set_idx] <= pend[set_idx] | set_mask;
    end
  end

  assign due = pend[q_idx][0];

  // R5: a parked activation always carries a delay the table can hold
  a_r5_dly_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |-> (set_dly != '0) && (int'(set_dly) <= MAX_DLY));

  // R6: parking and aging never collide, so no pending bit is lost
  a_r6_no_set_on_shift: assert property (@(posedge clk) disable iff (!rst_n)
    !(set_en && shift_en));
endmodule

// File: rtl/srs_pulse_timer.sv
module srs_pulse_timer #(
  parameter int PW_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic [PW_W-1:0] len,
  output logic            last
);
  logic [PW_W-1:0] cnt;
  logic [PW_W-1:0] len_eff;

  assign len_eff = (len == '0) ? PW_W'(1) : len;
  assign last    = run && (cnt >= len_eff - PW_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt <= '0;
    else if (!run || last) cnt <= '0;
    else                   cnt <= cnt + PW_W'(1);
  end

  // R7: every pulse starts counting from zero
  a_r7_fresh_count: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> (cnt == '0));
endmodule

// File: rtl/spike_route_seq.sv
module spike_route_seq #(
  parameter int N_SRC   = 8,
  parameter int N_ENT   = 32,
  parameter int SYN_W   = 6,
  parameter int MAX_DLY = 3,
  parameter int PW_W    = 4,
  localparam int ENT_W = $clog2(N_ENT),
  localparam int SRC_W = $clog2(N_SRC),
  localparam int CNT_W = $clog2(N_ENT + 1),
  localparam int DLY_W = $clog2(MAX_DLY + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_ent_we,
  input  logic [ENT_W-1:0] cfg_ent_idx,
  input  logic [SYN_W-1:0] cfg_ent_syn,
  input  logic [DLY_W-1:0] cfg_ent_dly,
  input  logic             cfg_src_we,
  input  logic [SRC_W-1:0] cfg_src_idx,
  input  logic [ENT_W-1:0] cfg_src_base,
  input  logic [CNT_W-1:0] cfg_src_cnt,
  input  logic [PW_W-1:0]  stim_len,
  input  logic [PW_W-1:0]  clr_len,
  output logic             rd_en,
  output logic [SRC_W-1:0] rd_addr,
  input  logic             rd_bit,
  output logic             set_n,
  output logic [SYN_W-1:0] syn_addr,
  output logic             stim_n,
  output logic             clr_n,
  output logic             round_done
);
  import srs_pkg::*;

  seq_state_t st, st_nx;

  logic [ENT_W-1:0] rel_idx, ptr, ent_ridx;
  logic [SRC_W-1:0] src;
  logic [CNT_W-1:0] left;

  logic [SYN_W-1:0] ent_syn;
  logic [DLY_W-1:0] ent_dly, dly_eff;
  logic [ENT_W-1:0] sbase;
  logic [CNT_W-1:0] scnt;
  logic             due, tmr_last, tmr_run;
  logic [PW_W-1:0]  tmr_len;

  logic last_src, last_rel, last_ent, hit, walk_end;
  logic set_req, pend_set, pend_shift;

  // ---------------- storage ----------------
  assign ent_ridx = (st == SQ_REL) ? rel_idx : ptr;

  srs_conn_store #(
    .N_SRC(N_SRC), .N_ENT(N_ENT), .SYN_W(SYN_W), .DLY_W(DLY_W)
  ) u_store (
    .clk       (clk),
    .ent_we    (cfg_ent_we),
    .ent_widx  (cfg_ent_idx),
    .ent_wsyn  (cfg_ent_syn),
    .ent_wdly  (cfg_ent_dly),
    .src_we    (cfg_src_we),
    .src_widx  (cfg_src_idx),
    .src_wbase (cfg_src_base),
    .src_wcnt  (cfg_src_cnt),
    .ent_ridx  (ent_ridx),
    .ent_rsyn  (ent_syn),
    .ent_rdly  (ent_dly),
    .src_ridx  (src),
    .src_rbase (sbase),
    .src_rcnt  (scnt)
  );

  assign dly_eff = (int'(ent_dly) > MAX_DLY) ? DLY_W'(MAX_DLY) : ent_dly;

  srs_pend_table #(
    .N_ENT(N_ENT), .MAX_DLY(MAX_DLY)
  ) u_pend (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_en   (pend_set),
    .set_idx  (ptr),
    .set_dly  (dly_eff),
    .shift_en (pend_shift),
    .q_idx    (rel_idx),
    .due      (due)
  );

  assign tmr_run = (st == SQ_STIM) || (st == SQ_CLR);
  assign tmr_len = (st == SQ_STIM) ? stim_len : clr_len;

  srs_pulse_timer #(.PW_W(PW_W)) u_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (tmr_run),
    .len   (tmr_len),
    .last  (tmr_last)
  );

  // ---------------- control ----------------
  assign last_src = (src == SRC_W'(N_SRC - 1));
  assign last_rel = (rel_idx == ENT_W'(N_ENT - 1));
  assign last_ent = (ptr == ENT_W'(N_ENT - 1));
  assign hit      = rd_bit && (scnt != '0);
  assign walk_end = (left == CNT_W'(1));

  assign rd_en   = (st == SQ_READ);
  assign rd_addr = src;

  always_comb begin
    set_req    = 1'b0;
    pend_set   = 1'b0;
    pend_shift = 1'b0;
    case (st)
      SQ_REL:   set_req    = due;
      SQ_SHIFT: pend_shift = 1'b1;
      SQ_WALK: begin
        set_req  = (dly_eff == '0);
        pend_set = (dly_eff != '0);
      end
      default: ;
    endcase
  end

  always_comb begin
    st_nx = st;
    case (st)
      SQ_REL:   if (last_rel) st_nx = SQ_SHIFT;
      SQ_SHIFT: st_nx = SQ_READ;
      SQ_READ: begin
        if (hit)           st_nx = SQ_WALK;
        else if (last_src) st_nx = SQ_STIM;
      end
      SQ_WALK: begin
        if (walk_end) st_nx = last_src ? SQ_STIM : SQ_READ;
      end
      SQ_STIM:  if (tmr_last) st_nx = SQ_CLR;
      SQ_CLR:   if (tmr_last) st_nx = SQ_DONE;
      SQ_DONE:  st_nx = SQ_REL;
      default:  st_nx = SQ_REL;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= SQ_REL;
      rel_idx <= '0;
      src     <= '0;
      ptr     <= '0;
      left    <= '0;
    end else begin
      st <= st_nx;
      case (st)
        SQ_REL:   rel_idx <= last_rel ? '0 : rel_idx + ENT_W'(1);
        SQ_SHIFT: src <= '0;
        SQ_READ: begin
          if (hit) begin
            ptr  <= sbase;
            left <= scnt;
          end else if (!last_src) begin
            src <= src + SRC_W'(1);
          end
        end
        SQ_WALK: begin
          ptr  <= last_ent ? '0 : ptr + ENT_W'(1);
          left <= left - CNT_W'(1);
          if (walk_end && !last_src) src <= src + SRC_W'(1);
        end
        SQ_DONE: rel_idx <= '0;
        default: ;
      endcase
    end
  end

  // ---------------- registered strobes ----------------
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      set_n      <= 1'b1;
      syn_addr   <= '0;
      stim_n     <= 1'b1;
      clr_n      <= 1'b1;
      round_done <= 1'b0;
    end else begin
      set_n      <= !set_req;
      syn_addr   <= set_req ? ent_syn : syn_addr;
      stim_n     <= !(st == SQ_STIM);
      clr_n      <= !(st == SQ_CLR);
      round_done <= (st == SQ_DONE);
    end
  end

  // ---------------- assertions ----------------
  // R7: global pulses never overlap
  a_r7_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(!stim_n && !clr_n));

  // R7: no activation strobe inside a global pulse
  a_r7_no_set_in_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    !set_n |-> (stim_n && clr_n));

  // R7: clear starts in the cycle stimulate ends
  a_r7_clr_after_stim: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stim_n) |-> !clr_n);

  // R8: round flag follows clear at once
  a_r8_done_after_clr: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clr_n) |-> round_done);

  // R8: round flag is a single cycle
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    round_done |=> !round_done);

  // R2: reads happen only outside the global pulses
  a_r2_read_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> (stim_n && clr_n));

  // R4: a read step itself never produces a strobe
  a_r4_read_no_set: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SQ_READ) |=> set_n);

  // R3: a table walk always has entries left to visit
  a_r3_walk_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SQ_WALK) |-> (left != '0));
endmodule

// File: tb/sim_spike_route_seq.sv
module sim_spike_route_seq;
  localparam int N_SRC   = 8;
  localparam int N_ENT   = 32;
  localparam int SYN_W   = 6;
  localparam int MAX_DLY = 3;
  localparam int PW_W    = 4;
  localparam int ENT_W = $clog2(N_ENT);
  localparam int SRC_W = $clog2(N_SRC);
  localparam int CNT_W = $clog2(N_ENT + 1);
  localparam int DLY_W = $clog2(MAX_DLY + 1);
  localparam int N_ROUNDS = 48;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic             rst_n = 1'b0;
  logic             cfg_ent_we = 1'b0;
  logic [ENT_W-1:0] cfg_ent_idx = '0;
  logic [SYN_W-1:0] cfg_ent_syn = '0;
  logic [DLY_W-1:0] cfg_ent_dly = '0;
  logic             cfg_src_we = 1'b0;
  logic [SRC_W-1:0] cfg_src_idx = '0;
  logic [ENT_W-1:0] cfg_src_base = '0;
  logic [CNT_W-1:0] cfg_src_cnt = '0;
  logic [PW_W-1:0]  stim_len = '0;
  logic [PW_W-1:0]  clr_len = '0;
  logic             rd_en, rd_bit, set_n, stim_n, clr_n, round_done;
  logic [SRC_W-1:0] rd_addr;
  logic [SYN_W-1:0] syn_addr;

  spike_route_seq #(
    .N_SRC(N_SRC), .N_ENT(N_ENT), .SYN_W(SYN_W), .MAX_DLY(MAX_DLY), .PW_W(PW_W)
  ) u0 (
    .clk(clk), .rst_n(rst_n),
    .cfg_ent_we(cfg_ent_we), .cfg_ent_idx(cfg_ent_idx),
    .cfg_ent_syn(cfg_ent_syn), .cfg_ent_dly(cfg_ent_dly),
    .cfg_src_we(cfg_src_we), .cfg_src_idx(cfg_src_idx),
    .cfg_src_base(cfg_src_base), .cfg_src_cnt(cfg_src_cnt),
    .stim_len(stim_len), .clr_len(clr_len),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_bit(rd_bit),
    .set_n(set_n), .syn_addr(syn_addr),
    .stim_n(stim_n), .clr_n(clr_n), .round_done(round_done)
  );

  // spike sources: cleared by a read
  logic [N_SRC-1:0] spk = '0;
  logic             ld = 1'b0;
  logic [N_SRC-1:0] ld_val = '0;
  always @(posedge clk) begin
    if (ld)         spk <= ld_val;
    else if (rd_en) spk[rd_addr] <= 1'b0;
  end
  assign rd_bit = rd_en & spk[rd_addr];

  // model
  int m_syn [N_ENT];
  int m_dly [N_ENT];
  int m_base[N_SRC];
  int m_cnt [N_SRC];
  bit pendb [N_ENT][MAX_DLY];
  int exp_q[$];
  int got_q[$];
  string round_tag = "R4 idle round";

  int total = 0, bad = 0;
  int done_cnt = 0;
  int rd_exp = 0, stim_run = 0, clr_run = 0;
  bit prev_done = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int eff(input int l);
    return (l == 0) ? 1 : l;
  endfunction

  task automatic build_expect(input logic [N_SRC-1:0] v);
    for (int e = 0; e < N_ENT; e++)
      if (pendb[e][0]) exp_q.push_back(m_syn[e]);
    for (int e = 0; e < N_ENT; e++)
      for (int k = 0; k < MAX_DLY; k++)
        pendb[e][k] = (k + 1 < MAX_DLY) ? pendb[e][k+1] : 1'b0;
    for (int s = 0; s < N_SRC; s++) begin
      if (v[s] && m_cnt[s] != 0) begin
        for (int j = 0; j < m_cnt[s]; j++) begin
          int e;
          e = (m_base[s] + j) % N_ENT;
          if (m_dly[e] == 0) exp_q.push_back(m_syn[e]);
          else pendb[e][m_dly[e]-1] = 1'b1;
        end
      end
    end
  endtask

  task automatic wr_ent(input int i, input int s, input int d);
    cfg_ent_idx = ENT_W'(i); cfg_ent_syn = SYN_W'(s); cfg_ent_dly = DLY_W'(d);
    cfg_ent_we = 1'b1;
    m_syn[i] = s; m_dly[i] = d;
    @(negedge clk);
    cfg_ent_we = 1'b0;
  endtask

  task automatic wr_src(input int i, input int b, input int c);
    cfg_src_idx = SRC_W'(i); cfg_src_base = ENT_W'(b); cfg_src_cnt = CNT_W'(c);
    cfg_src_we = 1'b1;
    m_base[i] = b; m_cnt[i] = c;
    @(negedge clk);
    cfg_src_we = 1'b0;
  endtask

  task automatic load_spikes(input logic [N_SRC-1:0] v);
    ld_val = v; ld = 1'b1;
    @(negedge clk);
    ld = 1'b0;
  endtask

  task automatic finish_up;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (!set_n) begin
        got_q.push_back(int'(syn_addr));
        chk(stim_n && clr_n, "R7 strobe outside pulses", {31'd0, stim_n & clr_n}, 1);
      end
      if (rd_en) begin
        chk(int'(rd_addr) == rd_exp, "R2 read order", int'(rd_addr), rd_exp);
        rd_exp++;
      end
      if (!stim_n) stim_run++;
      else if (stim_run != 0) begin
        chk(stim_run == eff(int'(stim_len)), "R7 stimulate width", stim_run, eff(int'(stim_len)));
        chk(!clr_n, "R7 clear begins as stimulate ends", {31'd0, clr_n}, 0);
        stim_run = 0;
      end
      if (!clr_n) clr_run++;
      else if (clr_run != 0) begin
        chk(clr_run == eff(int'(clr_len)), "R7 clear width", clr_run, eff(int'(clr_len)));
        chk(round_done, "R8 round flag after clear", {31'd0, round_done}, 1);
        clr_run = 0;
      end
      if (round_done) begin
        chk(!prev_done, "R8 round flag single cycle", {31'd0, prev_done}, 0);
        chk(rd_exp == N_SRC, "R2 reads per round", rd_exp, N_SRC);
        chk(spk == '0, "R2 reads clear spikes", int'(spk), 0);
        chk(got_q.size() == exp_q.size(), {round_tag, " strobe count"}, got_q.size(), exp_q.size());
        for (int i = 0; i < got_q.size() && i < exp_q.size(); i++)
          chk(got_q[i] == exp_q[i], {round_tag, " strobe address"}, got_q[i], exp_q[i]);
        got_q.delete();
        exp_q.delete();
        rd_exp = 0;
        done_cnt++;
      end
      prev_done = round_done;
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL R9 watchdog expired actual=%0d expected=%0d", done_cnt, N_ROUNDS);
    finish_up();
  end

  initial begin
    logic [N_SRC-1:0] v;
    void'($urandom(32'd20240611));
    for (int e = 0; e < N_ENT; e++)
      for (int k = 0; k < MAX_DLY; k++) pendb[e][k] = 1'b0;
    @(negedge clk);
    // directed table
    wr_ent(0, 5, 0);  wr_ent(1, 9, 0);  wr_ent(2, 12, 0);
    wr_ent(3, 50, 0);
    wr_ent(4, 20, 0); wr_ent(5, 21, 1); wr_ent(6, 22, 2); wr_ent(7, 23, 3);
    wr_ent(8, 30, 1); wr_ent(9, 31, 1); wr_ent(10, 31, 0); wr_ent(11, 60, 2);
    for (int e = 12; e < 30; e++) wr_ent(e, int'($urandom % 64), int'($urandom % 4));
    wr_ent(30, 40, 0); wr_ent(31, 41, 1);
    wr_src(0, 0, 3);  wr_src(1, 3, 0);  wr_src(2, 4, 4);  wr_src(3, 8, 2);
    wr_src(4, 9, 2);  wr_src(5, 30, 4); wr_src(6, 12, 6); wr_src(7, 18, 12);
    stim_len = '0; clr_len = 4'd3;
    load_spikes('0);
    // R1: reset state
    chk(set_n && stim_n && clr_n, "R1 strobes idle in reset", {31'd0, set_n & stim_n & clr_n}, 1);
    chk(!round_done && !rd_en, "R1 round flag and read idle in reset", {31'd0, round_done | rd_en}, 0);
    round_tag = "R4 nothing spiking";
    build_expect('0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(set_n && stim_n && clr_n && !round_done, "R1 idle after reset", {31'd0, set_n & stim_n & clr_n & ~round_done}, 1);

    for (int r = 1; r < N_ROUNDS; r++) begin
      while (done_cnt < r) @(negedge clk);
      case (r)
        1: begin v = 8'b0000_0010; round_tag = "R4 zero-count source"; stim_len = 4'd2; clr_len = 4'd0; end
        2: begin v = 8'b0000_0001; round_tag = "R3 fan-out in order"; end
        3: begin v = 8'b0000_0100; round_tag = "R5 delay zero part"; stim_len = 4'd5; clr_len = 4'd1; end
        4: begin v = 8'b0001_1000; round_tag = "R5 one-round delay R6 shared entry"; end
        5: begin v = 8'b0010_0000; round_tag = "R6 single issue R3 wrap"; end
        6: begin v = 8'b0000_0000; round_tag = "R5 long delays"; end
        default: begin
          v = N_SRC'($urandom);
          round_tag = "R9 random round";
          stim_len = PW_W'($urandom % 6);
          clr_len  = PW_W'($urandom % 6);
        end
      endcase
      load_spikes(v);
      build_expect(v);
    end
    while (done_cnt < N_ROUNDS) @(negedge clk);
    chk(done_cnt == N_ROUNDS, "R9 rounds repeat", done_cnt, N_ROUNDS);
    finish_up();
  end
endmodule